// File: doc/BRIEF.md
# Windowed Watchdog with Ordered Service Sequence

This block is a watchdog timer built around a down counter that software must refresh before it reaches zero. The refresh, called a service, is an ordered pair of 16-bit words written to one service address. The pair is either a fixed constant pair or, in keyed mode, two values drawn from a simple pseudorandom recurrence. An optional window restricts servicing to the late part of the count. In escalation mode the first expiry raises an interrupt and restarts the count, and only a second expiry in a row requests a reset.

A small word-addressed register bus gives access to a control word, a timeout value, a window value, an interrupt flag, the service address (which reads back the current key) and a read-only view of the counter. A hard lock and a soft lock make the configuration read-only. Each bus master has its own access-enable bit. An access that breaks any rule either returns a bus error or, if configured to, requests a reset. A debug-halt input can freeze the counter.

Address map (word index on `bus_addr`): 0 control, 1 timeout, 2 window, 3 interrupt flag, 4 service/key, 5 counter. Control bits: 0 enable, 1 freeze-in-debug, 2 clock select (stored only), 3 soft lock, 4 hard lock, 5 escalation (interrupt then reset), 6 window mode, 7 reset-on-invalid, 8 keyed mode, 12+i access enable of master i.

Top module: `wdog_win`

## Requirements
- R1: After reset, control reads 0xF000, timeout reads RESET_TO, window reads 0, the key reads 0, and `irq`, `rst_req` and `bus_err` are 0. Read data and `bus_err` appear in the cycle after the request. Any access that is not a valid read returns 0 on `bus_rdata`.
- R2: While the enable bit (bit 0) is 0, the counter holds the timeout value. While it is 1 and the counter is not frozen, the counter drops by one per clock and reloads from the timeout value after reaching zero.
- R3: In fixed mode, writing 0xA602 and then 0xB480 to address 4 reloads the counter with the timeout value. Any other service word, or the same words in the other order, is invalid and does not reload.
- R4: With escalation (bit 5) clear, an expiry sets `rst_req`, which then stays 1 until reset.
- R5: With escalation set, the first expiry sets the flag (address 3 bit 0, driven on `irq`) and reloads the counter. An expiry while the flag is still set raises `rst_req`. Writing 1 to address 3 bit 0 clears the flag and does not count as a service.
- R6: With window mode (bit 6) set, a service word is accepted only while the counter is below the window value. Otherwise the word is invalid and does not reload.
- R7: With keyed mode (bit 8) set, the expected words are f(K) and then f(f(K)), where f(x) = (17x + 3) mod 65536 and K is the key register (read at address 4). A completed keyed service sets K to the second word.
- R8: Setting the hard lock (bit 4) makes writes to addresses 0 to 2 invalid and without effect. Only reset clears the hard lock, and the unlock sequence does not clear it.
- R9: Setting the soft lock (bit 3) makes writes to addresses 0 to 2 invalid and without effect. Writing 0xC520 and then 0xD928 to address 4 clears the soft lock.
- R10: An invalid access is any bad service word, a write to a locked configuration address, a write to address 5 to 7, or a read of address 6 or 7. With reset-on-invalid (bit 7) set and the watchdog enabled, it sets `rst_req`. Otherwise it pulses `bus_err` for one cycle.
- R11: An access from master i whose enable bit 12+i is 0 is invalid. Its write has no effect and its read returns 0.
- R12: With freeze (bit 1) set and `dbg_halt` high, the counter holds its value. With freeze clear, `dbg_halt` has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_mst | input | MIDW | Index of the requesting master |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| dbg_halt | input | 1 | Debugger has halted the processor |
| bus_rdata | output | 16 | Read data, registered |
| bus_err | output | 1 | Invalid-access error pulse, registered |
| irq | output | 1 | Expiry interrupt flag |
| rst_req | output | 1 | Sticky reset request |

## Verification
A wrong counter value appears in the very next read of address 5 and, if no service follows, as an early or late `irq` or `rst_req` edge after at most one timeout period. A sequencer or key that goes astray shows up in the cycle after the next service word: either a spurious `bus_err` or a missing reload, which then shows as a late expiry. A lock or master-enable bit held in the wrong state shows in the cycle after the next configuration access, through `bus_err` or through a readback that changes where it should not. The bench model compares all four outputs on every clock, so any such deviation is caught in the first cycle it becomes visible.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 16;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TO   = 3'd1;
  localparam logic [2:0] A_WIN  = 3'd2;
  localparam logic [2:0] A_FLAG = 3'd3;
  localparam logic [2:0] A_SVC  = 3'd4;
  localparam logic [2:0] A_CNT  = 3'd5;

  localparam int B_EN    = 0;
  localparam int B_FRZ   = 1;
  localparam int B_CLK   = 2;
  localparam int B_SLK   = 3;
  localparam int B_HLK   = 4;
  localparam int B_ITR   = 5;
  localparam int B_WIN   = 6;
  localparam int B_RINV  = 7;
  localparam int B_KEYED = 8;
  localparam int MAP_LSB = 12;

  localparam logic [DW-1:0] SVC_W1 = 16'hA602;
  localparam logic [DW-1:0] SVC_W2 = 16'hB480;
  localparam logic [DW-1:0] UNL_W1 = 16'hC520;
  localparam logic [DW-1:0] UNL_W2 = 16'hD928;

  typedef enum logic [1:0] {ST_IDLE, ST_SVC1, ST_UNL1} svc_st_e;

  function automatic logic [DW-1:0] key_next(input logic [DW-1:0] k);
    return k * 16'd17 + 16'd3;
  endfunction
endpackage

// File: rtl/wdog_svc.sv
module wdog_svc
  import wdog_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          keyed,
  input  logic          winm,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] win,
  output logic          ok,
  output logic          bad,
  output logic          unlk,
  output logic [DW-1:0] key
);
  svc_st_e       st_q, st_n;
  logic [DW-1:0] key_q;
  logic [DW-1:0] w1, w2;
  logic          in_win;

  assign w1     = keyed ? key_next(key_q) : SVC_W1;
  assign w2     = keyed ? key_next(w1) : SVC_W2;
  assign in_win = !winm || (cnt < win);
  assign key    = key_q;

  always_comb begin
    st_n = st_q;
    ok   = 1'b0;
    bad  = 1'b0;
    unlk = 1'b0;
    if (wr) begin
      st_n = ST_IDLE;
      if (st_q == ST_SVC1 && wdata == w2) begin
        if (in_win) ok = 1'b1;
        else        bad = 1'b1;
      end else if (wdata == w1) begin
        if (in_win) st_n = ST_SVC1;
        else        bad = 1'b1;
      end else if (wdata == UNL_W1) begin
        st_n = ST_UNL1;
      end else if (st_q == ST_UNL1 && wdata == UNL_W2) begin
        unlk = 1'b1;
      end else begin
        bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      key_q <= '0;
    end else begin
      st_q <= st_n;
      if (ok && keyed) key_q <= w2;
    end
  end

  // R3: one outcome per service word at most
  assert_svc_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ok, bad, unlk}));
  // R7: the key moves only on a completed keyed service
  assert_key_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(ok && keyed) |=> $stable(key_q));
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          frz,
  input  logic          halt,
  input  logic          itr,
  input  logic [CW-1:0] to_val,
  input  logic          reload,
  input  logic          flag_clr,
  input  logic          inv_rst,
  output logic [CW-1:0] cnt,
  output logic          irq,
  output logic          rst_req
);
  logic [CW-1:0] cnt_q;
  logic          flag_q, rst_q;
  logic          run, expire;

  assign run    = en && !(frz && halt);
  assign expire = run && (cnt_q == '0) && !reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= to_val;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (!en || reload)   cnt_q <= to_val;
      else if (run) begin
        if (cnt_q == '0)   cnt_q <= to_val;
        else               cnt_q <= cnt_q - 1'b1;
      end
      if (expire && itr && !flag_q) flag_q <= 1'b1;
      else if (flag_clr)            flag_q <= 1'b0;
      if ((expire && (!itr || flag_q)) || inv_rst) rst_q <= 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign irq     = flag_q;
  assign rst_req = rst_q;

  // R4: a reset request is held until reset
  assert_rst_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    rst_q |=> rst_q);
  // R12: frozen counter does not move
  assert_freeze_R12: assert property (@(posedge clk) disable iff (rst)
    (en && frz && halt && !reload) |=> $stable(cnt_q));
  // R5: in escalation mode a first expiry never requests reset
  assert_itr_first_R5: assert property (@(posedge clk) disable iff (rst)
    (itr && !flag_q && !inv_rst && !rst_q) |=> !rst_q);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int            CW       = 16,
  parameter int            NMAST    = 4,
  parameter int            MIDW     = 2,
  parameter logic [CW-1:0] RESET_TO = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            we,
  input  logic [MIDW-1:0] mst,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic [CW-1:0]   cnt_val,
  input  logic [DW-1:0]   key_val,
  input  logic            flag,
  input  logic            svc_bad,
  input  logic            unlk,
  output logic            en,
  output logic            frz,
  output logic            itr,
  output logic            winm,
  output logic            keyed,
  output logic [CW-1:0]   to_val,
  output logic [CW-1:0]   win_val,
  output logic            wr_svc,
  output logic            flag_clr,
  output logic            inv_rst,
  output logic            bus_err,
  output logic [DW-1:0]   rdata
);
  localparam int            MSLOTS    = 1 << MIDW;
  localparam logic [DW-1:0] MAP_FIELD = DW'(((1 << NMAST) - 1) << MAP_LSB);
  localparam logic [DW-1:0] HLK_BIT   = DW'(1) << B_HLK;
  localparam logic [DW-1:0] WMASK     = (16'h01FF & ~HLK_BIT) | MAP_FIELD;

  logic [DW-1:0]     ctrl_q;
  logic [CW-1:0]     to_q, win_q;
  logic [MSLOTS-1:0] map_ext;
  logic              mst_ok, locked, rinv, inv, cfg_wr;
  logic [DW-1:0]     rmux;

  assign map_ext = MSLOTS'(ctrl_q[MAP_LSB +: NMAST]);
  assign mst_ok  = map_ext[mst];
  assign locked  = ctrl_q[B_SLK] | ctrl_q[B_HLK];
  assign en      = ctrl_q[B_EN];
  assign frz     = ctrl_q[B_FRZ];
  assign itr     = ctrl_q[B_ITR];
  assign winm    = ctrl_q[B_WIN];
  assign keyed   = ctrl_q[B_KEYED];
  assign rinv    = ctrl_q[B_RINV];
  assign to_val  = to_q;
  assign win_val = win_q;

  always_comb begin
    inv = 1'b0;
    if (req) begin
      if (!mst_ok) inv = 1'b1;
      else if (we) begin
        case (addr)
          A_CTRL, A_TO, A_WIN: inv = locked;
          A_FLAG:              inv = 1'b0;
          A_SVC:               inv = svc_bad;
          default:             inv = 1'b1;
        endcase
      end else begin
        inv = (addr > A_CNT);
      end
    end
  end

  assign wr_svc   = req && we && mst_ok && (addr == A_SVC);
  assign flag_clr = req && we && mst_ok && (addr == A_FLAG) && wdata[0];
  assign cfg_wr   = req && we && mst_ok && !locked;
  assign inv_rst  = inv && rinv && en;

  always_comb begin
    case (addr)
      A_CTRL:  rmux = ctrl_q;
      A_TO:    rmux = DW'(to_q);
      A_WIN:   rmux = DW'(win_q);
      A_FLAG:  rmux = DW'(flag);
      A_SVC:   rmux = key_val;
      A_CNT:   rmux = DW'(cnt_val);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= MAP_FIELD;
      to_q    <= RESET_TO;
      win_q   <= '0;
      bus_err <= 1'b0;
      rdata   <= '0;
    end else begin
      bus_err <= inv && !(rinv && en);
      rdata   <= (req && !we && !inv) ? rmux : '0;
      if (unlk) ctrl_q[B_SLK] <= 1'b0;
      if (cfg_wr) begin
        case (addr)
          A_CTRL:  ctrl_q <= (wdata & WMASK) | ((ctrl_q | wdata) & HLK_BIT);
          A_TO:    to_q   <= wdata[CW-1:0];
          A_WIN:   win_q  <= wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  // R8: hard lock is only cleared by reset
  assert_hlk_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_HLK] |=> ctrl_q[B_HLK]);
  // R8: hard-locked timing values do not change
  assert_hlk_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_HLK] |=> ($stable(to_q) && $stable(win_q)));
  // R11: a denied read returns zero
  assert_denied_read_R11: assert property (@(posedge clk) disable iff (rst)
    (req && !we && !mst_ok) |=> (rdata == '0));
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_pkg::*;
#(
  parameter int            CW       = 16,
  parameter int            NMAST    = 4,
  parameter int            MIDW     = (NMAST > 1) ? $clog2(NMAST) : 1,
  parameter logic [CW-1:0] RESET_TO = 16'h0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic [MIDW-1:0] bus_mst,
  input  logic [2:0]      bus_addr,
  input  logic [15:0]     bus_wdata,
  input  logic            dbg_halt,
  output logic [15:0]     bus_rdata,
  output logic            bus_err,
  output logic            irq,
  output logic            rst_req
);
  logic          en, frz, itr, winm, keyed;
  logic [CW-1:0] to_val, win_val, cnt;
  logic          wr_svc, flag_clr, inv_rst;
  logic          svc_ok, svc_bad, unlk;
  logic [DW-1:0] key;

  wdog_regs #(.CW(CW), .NMAST(NMAST), .MIDW(MIDW), .RESET_TO(RESET_TO)) u_regs (
    .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .mst(bus_mst),
    .addr(bus_addr), .wdata(bus_wdata), .cnt_val(cnt), .key_val(key),
    .flag(irq), .svc_bad(svc_bad), .unlk(unlk), .en(en), .frz(frz),
    .itr(itr), .winm(winm), .keyed(keyed), .to_val(to_val),
    .win_val(win_val), .wr_svc(wr_svc), .flag_clr(flag_clr),
    .inv_rst(inv_rst), .bus_err(bus_err), .rdata(bus_rdata)
  );

  wdog_svc #(.CW(CW)) u_svc (
    .clk(clk), .rst(rst), .wr(wr_svc), .wdata(bus_wdata), .keyed(keyed),
    .winm(winm), .cnt(cnt), .win(win_val), .ok(svc_ok), .bad(svc_bad),
    .unlk(unlk), .key(key)
  );

  wdog_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .frz(frz), .halt(dbg_halt), .itr(itr),
    .to_val(to_val), .reload(svc_ok), .flag_clr(flag_clr),
    .inv_rst(inv_rst), .cnt(cnt), .irq(irq), .rst_req(rst_req)
  );
endmodule

// File: tb/wdog_win_bench.sv
`timescale 1ns/1ps
module wdog_win_bench;
  localparam int RTO = 64;

  logic        clk = 0, rst = 1;
  logic        bus_req = 0, bus_we = 0, dbg_halt = 0;
  logic [1:0]  bus_mst = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        bus_err, irq, rst_req;

  int errors = 0, checks = 0;
  bit started = 0;

  always #10 clk = ~clk;

  wdog_win #(.RESET_TO(16'(RTO))) u_wdog_win (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_mst(bus_mst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .dbg_halt(dbg_halt), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq(irq), .rst_req(rst_req)
  );

  // Behavioural reference model
  int m_ctrl, m_to, m_win, m_flag, m_key, m_stage, m_cnt, m_rst, m_err, m_rd;

  function automatic int fkey(int k);
    return (17 * k + 3) % 65536;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 'hF000; m_to = RTO; m_win = 0; m_flag = 0; m_key = 0;
      m_stage = 0; m_cnt = RTO; m_rst = 0; m_err = 0; m_rd = 0;
      started = 1;
    end else begin
      int a, d, w1, w2, rv, ns, n_cnt, n_flag, n_ctrl;
      bit en, frz, itr, wm, rinv, kd, lock, mok, inv, ok, unl, run, tmo, rd_ok;
      a = int'(bus_addr); d = int'(bus_wdata);
      en = m_ctrl[0]; frz = m_ctrl[1]; lock = m_ctrl[3] | m_ctrl[4];
      itr = m_ctrl[5]; wm = m_ctrl[6]; rinv = m_ctrl[7]; kd = m_ctrl[8];
      mok = m_ctrl[12 + int'(bus_mst)];
      inv = 0; ok = 0; unl = 0; ns = m_stage; n_ctrl = m_ctrl;
      w1 = kd ? fkey(m_key) : 'hA602;
      w2 = kd ? fkey(w1) : 'hB480;
      if (bus_req) begin
        if (!mok) inv = 1;
        else if (bus_we) begin
          if (a <= 2) inv = lock;
          else if (a == 4) begin
            bit inw;
            inw = !wm || (m_cnt < m_win);
            ns = 0;
            if (m_stage == 1 && d == w2) begin if (inw) ok = 1; else inv = 1; end
            else if (d == w1) begin if (inw) ns = 1; else inv = 1; end
            else if (d == 'hC520) ns = 2;
            else if (m_stage == 2 && d == 'hD928) unl = 1;
            else inv = 1;
          end else if (a != 3) inv = 1;
        end else inv = (a > 5);
      end
      case (a)
        0: rv = m_ctrl; 1: rv = m_to; 2: rv = m_win; 3: rv = m_flag;
        4: rv = m_key; 5: rv = m_cnt; default: rv = 0;
      endcase
      rd_ok = bus_req && !bus_we && !inv;
      m_rd  = rd_ok ? rv : 0;
      m_err = inv && !(rinv && en);
      if (inv && rinv && en) m_rst = 1;
      run = en && !(frz && dbg_halt);
      tmo = run && m_cnt == 0 && !ok;
      if (!en || ok) n_cnt = m_to;
      else if (run) n_cnt = (m_cnt == 0) ? m_to : m_cnt - 1;
      else n_cnt = m_cnt;
      n_flag = m_flag;
      if (tmo && itr && m_flag == 0) n_flag = 1;
      else if (bus_req && bus_we && mok && a == 3 && d[0]) n_flag = 0;
      if (tmo && (!itr || m_flag == 1)) m_rst = 1;
      if (unl) n_ctrl[3] = 0;
      if (bus_req && bus_we && mok && !lock) begin
        if (a == 0) n_ctrl = (d & 'hF1EF) | ((m_ctrl | d) & 'h10);
        if (a == 1) m_to = d;
        if (a == 2) m_win = d;
      end
      if (ok && kd) m_key = w2;
      m_ctrl = n_ctrl; m_cnt = n_cnt; m_flag = n_flag; m_stage = ns;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks += 4;
      if (irq !== m_flag[0]) begin errors++; $display("FAIL R5 irq got %0d exp %0d", irq, m_flag); end
      if (rst_req !== m_rst[0]) begin errors++; $display("FAIL R4 rst_req got %0d exp %0d", rst_req, m_rst); end
      if (bus_err !== m_err[0]) begin errors++; $display("FAIL R10 bus_err got %0d exp %0d", bus_err, m_err); end
      if (bus_rdata !== 16'(m_rd)) begin errors++; $display("FAIL R1 rdata got %0h exp %0h", bus_rdata, m_rd); end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic acc(int m, bit we, int a, int d, output int rd, output int er);
    bus_req = 1; bus_we = we; bus_mst = 2'(m); bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk);
    rd = int'(bus_rdata); er = int'(bus_err);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; dbg_halt = 0;
    idle(3);
    rst = 0;
  endtask

  int rd, er, v1, v2;

  initial begin
    @(negedge clk);
    // R1 reset state
    do_reset();
    chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0); chk("R1 bus_err", bus_err, 0);
    acc(0, 0, 0, 0, rd, er); chk("R1 ctrl", rd, 'hF000);
    acc(0, 0, 1, 0, rd, er); chk("R1 timeout", rd, RTO);
    acc(0, 0, 2, 0, rd, er); chk("R1 window", rd, 0);
    // R2 count down
    acc(0, 1, 1, 100, rd, er);
    acc(0, 1, 0, 'hF001, rd, er);
    acc(0, 0, 5, 0, rd, v1); acc(0, 0, 5, 0, v2, er);
    chk("R2 first count", rd, 100); chk("R2 next count", v2, 99);
    // R3 fixed service
    idle(10);
    acc(0, 1, 4, 'hA602, rd, er); chk("R3 word1 err", er, 0);
    acc(0, 1, 4, 'hB480, rd, er); chk("R3 word2 err", er, 0);
    acc(0, 0, 5, 0, rd, er); chk("R3 reloaded", rd, 100);
    acc(0, 1, 4, 'hB480, rd, er); chk("R3 wrong order err", er, 1);
    // R10 unmapped read, R11 master disable
    acc(0, 0, 7, 0, rd, er); chk("R10 unmapped err", er, 1); chk("R10 unmapped data", rd, 0);
    do_reset();
    acc(0, 1, 0, 'hD001, rd, er);
    acc(1, 0, 0, 0, rd, er); chk("R11 denied err", er, 1); chk("R11 denied data", rd, 0);
    acc(1, 1, 1, 7, rd, er); chk("R11 denied write err", er, 1);
    acc(0, 0, 1, 0, rd, er); chk("R11 write no effect", rd, RTO);
    acc(0, 1, 0, 'hF081, rd, er);
    acc(0, 1, 4, 'hB480, rd, er); chk("R10 reset not error", er, 0);
    chk("R10 reset on invalid", rst_req, 1);
    // R7 keyed service
    do_reset();
    acc(0, 0, 4, 0, rd, er); chk("R7 key reset", rd, 0);
    acc(0, 1, 0, 'hF101, rd, er);
    acc(0, 1, 4, 3, rd, er); chk("R7 key1 err", er, 0);
    acc(0, 1, 4, 54, rd, er); chk("R7 key2 err", er, 0);
    acc(0, 0, 4, 0, rd, er); chk("R7 key updated", rd, 54);
    acc(0, 1, 4, 'hA602, rd, er); chk("R7 fixed word rejected", er, 1);
    acc(0, 1, 4, 921, rd, er); acc(0, 1, 4, 15660, rd, er); chk("R7 second keyed service", er, 0);
    // R9 soft lock
    do_reset();
    acc(0, 1, 0, 'hF008, rd, er);
    acc(0, 1, 1, 5, rd, er); chk("R9 locked write err", er, 1);
    acc(0, 0, 1, 0, rd, er); chk("R9 locked unchanged", rd, RTO);
    acc(0, 1, 4, 'hC520, rd, er); acc(0, 1, 4, 'hD928, rd, er); chk("R9 unlock err", er, 0);
    acc(0, 1, 1, 5, rd, er); chk("R9 unlocked write", er, 0);
    acc(0, 0, 1, 0, rd, er); chk("R9 new timeout", rd, 5);
    // R8 hard lock
    do_reset();
    acc(0, 1, 0, 'hF010, rd, er);
    acc(0, 1, 2, 3, rd, er); chk("R8 locked err", er, 1);
    acc(0, 1, 4, 'hC520, rd, er); acc(0, 1, 4, 'hD928, rd, er);
    acc(0, 1, 2, 3, rd, er); chk("R8 still locked", er, 1);
    acc(0, 0, 0, 0, rd, er); chk("R8 ctrl kept", rd, 'hF010);
    // R4 plain expiry
    do_reset();
    acc(0, 1, 1, 20, rd, er); acc(0, 1, 0, 'hF001, rd, er);
    idle(10); chk("R4 not yet", rst_req, 0);
    idle(20); chk("R4 expired", rst_req, 1);
    // R5 escalation
    do_reset();
    acc(0, 1, 1, 20, rd, er); acc(0, 1, 0, 'hF021, rd, er);
    idle(25); chk("R5 first irq", irq, 1); chk("R5 no reset yet", rst_req, 0);
    idle(20); chk("R5 second expiry", rst_req, 1);
    do_reset();
    acc(0, 1, 1, 20, rd, er); acc(0, 1, 0, 'hF021, rd, er);
    idle(25); chk("R5 irq set", irq, 1);
    acc(0, 1, 3, 1, rd, er); chk("R5 cleared", irq, 0);
    idle(19); chk("R5 clear not service", irq, 1); chk("R5 cleared no reset", rst_req, 0);
    // R6 window
    do_reset();
    acc(0, 1, 1, 100, rd, er); acc(0, 1, 2, 10, rd, er); acc(0, 1, 0, 'hF041, rd, er);
    acc(0, 1, 4, 'hA602, rd, er); chk("R6 early err", er, 1);
    idle(95);
    acc(0, 1, 4, 'hA602, rd, er); chk("R6 in window w1", er, 0);
    acc(0, 1, 4, 'hB480, rd, er); chk("R6 in window w2", er, 0);
    acc(0, 0, 5, 0, rd, er); chk("R6 reloaded", rd, 100);
    // R12 freeze
    do_reset();
    acc(0, 1, 1, 100, rd, er); acc(0, 1, 0, 'hF003, rd, er);
    dbg_halt = 1;
    acc(0, 0, 5, 0, v1, er); acc(0, 0, 5, 0, v2, er); chk("R12 frozen", v2, v1);
    acc(0, 1, 0, 'hF001, rd, er);
    acc(0, 0, 5, 0, v1, er); acc(0, 0, 5, 0, v2, er); chk("R12 halt ignored", v2, v1 - 1);
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule